// File: doc/BRIEF.md
# Serial Line Break Detector

This block monitors the serial receive line on its own, next to the normal character receiver, and reports break fields of the kind that open a LIN frame. It looks for a falling edge that could be a start bit. It then samples the line once per bit at the mid-bit tick and counts how many sampled bits are low in a row. The start bit counts as the first of these. When the count reaches the selected break length (10 or 11 bits), a sticky break flag is raised and a one-cycle interrupt pulse is issued. If the line is sampled high before that length is reached, the attempt is dropped and the block waits for a new falling edge.

After a break is found, the block stays quiet until a bit tick samples the line high again (the delimiter) and then a new falling edge appears. A long low period therefore gives only one report. Deasserting the enable discards any count in progress. The flag stays set until the clear strobe is pulsed. The RX input must already be synchronised to `clk`. `bit_tick` is a one-cycle pulse at the middle of each bit period.

Top module: `lin_break_detect`

## Requirements
- R1: After synchronous reset, `brk_flag` and `brk_irq` are 0, and the block waits for a falling edge on `rx_in`.
- R2: With `len_sel`=0, `brk_flag` becomes 1 in the cycle after the bit tick that samples the 10th consecutive low bit. The start bit is counted as the first low bit. Nine low bits do not set the flag.
- R3: With `len_sel`=1, eleven consecutive low bits are needed. Ten low bits followed by a high sample leave `brk_flag` at 0.
- R4: A high sample before the threshold cancels the attempt. A new attempt begins only after a new falling edge, and it can then succeed.
- R5: `brk_flag` stays at 1 until `clr` is pulsed, and it reads 0 in the cycle after the pulse. When `clr` and a detection occur in the same cycle, the flag stays at 1.
- R6: Each detection produces exactly one `brk_irq` pulse, one cycle long, in the same cycle in which the flag reflects that detection.
- R7: After a detection, no further detection occurs until a bit tick samples the line high (the delimiter) and a new falling edge follows. A low run of any length gives one detection.
- R8: While `en` is 0, nothing is detected and any partial count is discarded. A line that is already low when `en` rises does not start a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables break search |
| rx_in | input | 1 | Synchronised serial receive line (idle high) |
| bit_tick | input | 1 | One-cycle pulse at each mid-bit sample point |
| len_sel | input | 1 | Break length: 0 selects 10 bits, 1 selects 11 bits |
| clr | input | 1 | Clears the break flag |
| brk_flag | output | 1 | Sticky break-detected flag |
| brk_irq | output | 1 | One-cycle pulse per detection |

## Verification
The bench builds the block with the defaults: break lengths of 10 and 11 bits and the interrupt pulse generated. Both thresholds can then be reached exactly, one bit short, and far beyond. Because the bench drives the bit ticks itself, it controls the exact sample that completes or cancels a run. This puts within reach the cases of clear and detection in the same cycle, a run cancelled one bit before the threshold, and the enable dropping in the middle of a run.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

    localparam int unsigned BRK_SHORT_DEF = 10;
    localparam int unsigned BRK_LONG_DEF  = 11;

    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_HUNT  = 2'd1,
        ST_DELIM = 2'd2
    } brk_state_e;

    typedef struct packed {
        logic det;
        logic busy;
    } brk_evt_t;

    function automatic int unsigned cnt_width(input int unsigned max_bits);
        return $clog2(max_bits + 1);
    endfunction

endpackage

// File: rtl/lin_brk_edge.sv
module lin_brk_edge (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic fall
);
    logic rx_prev;

    always_ff @(posedge clk) begin
        if (rst) rx_prev <= 1'b1;
        else     rx_prev <= rx_in;
    end

    assign fall = rx_prev & ~rx_in;

    a_r4_fall_needs_high: assert property (@(posedge clk) disable iff (rst)
        fall |-> $past(rx_in));
endmodule

// File: rtl/lin_brk_run.sv
module lin_brk_run
    import lin_brk_pkg::*;
#(
    parameter int unsigned SHORT_BITS = BRK_SHORT_DEF,
    parameter int unsigned LONG_BITS  = BRK_LONG_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     fall,
    input  logic     rx_in,
    input  logic     bit_tick,
    input  logic     len_sel,
    output brk_evt_t evt
);
    localparam int unsigned CNT_W = cnt_width(LONG_BITS);

    brk_state_e       state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt, cnt_inc, thr;
    logic             det;

    assign thr     = len_sel ? CNT_W'(LONG_BITS) : CNT_W'(SHORT_BITS);
    assign cnt_inc = cnt + CNT_W'(1);

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        det       = 1'b0;
        if (!en) begin
            nxt_state = ST_ARM;
            nxt_cnt   = '0;
        end else begin
            unique case (state)
                ST_ARM: begin
                    if (fall) begin
                        nxt_state = ST_HUNT;
                        nxt_cnt   = '0;
                    end
                end
                ST_HUNT: begin
                    if (bit_tick) begin
                        if (rx_in) begin
                            nxt_state = ST_ARM;
                            nxt_cnt   = '0;
                        end else if (cnt_inc >= thr) begin
                            det       = 1'b1;
                            nxt_state = ST_DELIM;
                            nxt_cnt   = '0;
                        end else begin
                            nxt_cnt = cnt_inc;
                        end
                    end
                end
                ST_DELIM: begin
                    if (bit_tick && rx_in) nxt_state = ST_ARM;
                end
                default: begin
                    nxt_state = ST_ARM;
                    nxt_cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ARM;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    assign evt.det  = det;
    assign evt.busy = (state != ST_ARM);

    a_r8_disable_rearms: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == ST_ARM) && (cnt == '0));
    a_r4_high_cancels: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_HUNT && bit_tick && rx_in) |=> state == ST_ARM);
    a_r7_det_waits_delim: assert property (@(posedge clk) disable iff (rst)
        (en && det) |=> state == ST_DELIM);
    a_r2_cnt_below_limit: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(LONG_BITS));
endmodule

// File: rtl/lin_brk_flag.sv
module lin_brk_flag #(
    parameter bit IRQ_PULSE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic det,
    input  logic clr,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (det) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    generate
        if (IRQ_PULSE) begin : g_irq
            logic irq_q;
            always_ff @(posedge clk) begin
                if (rst) irq_q <= 1'b0;
                else     irq_q <= det;
            end
            assign irq = irq_q;

            a_r6_irq_with_flag: assert property (@(posedge clk) disable iff (rst)
                irq |-> flag);
            a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
                irq |=> !irq);
        end else begin : g_no_irq
            assign irq = 1'b0;
        end
    endgenerate

    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !det) |=> !flag);
endmodule

// File: rtl/lin_break_detect.sv
module lin_break_detect
    import lin_brk_pkg::*;
#(
    parameter int unsigned SHORT_BITS = BRK_SHORT_DEF,
    parameter int unsigned LONG_BITS  = BRK_LONG_DEF,
    parameter bit          IRQ_PULSE  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rx_in,
    input  logic bit_tick,
    input  logic len_sel,
    input  logic clr,
    output logic brk_flag,
    output logic brk_irq
);
    logic     fall;
    brk_evt_t evt;

    lin_brk_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_in),
        .fall  (fall)
    );

    lin_brk_run #(
        .SHORT_BITS (SHORT_BITS),
        .LONG_BITS  (LONG_BITS)
    ) u_run (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .fall     (fall),
        .rx_in    (rx_in),
        .bit_tick (bit_tick),
        .len_sel  (len_sel),
        .evt      (evt)
    );

    lin_brk_flag #(
        .IRQ_PULSE (IRQ_PULSE)
    ) u_flag (
        .clk  (clk),
        .rst  (rst),
        .det  (evt.det),
        .clr  (clr),
        .flag (brk_flag),
        .irq  (brk_irq)
    );

    a_r8_no_det_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> !brk_irq);
endmodule

// File: tb/lin_break_detect_bench.sv
module lin_break_detect_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, rx_in = 1'b1, bit_tick = 1'b0, len_sel = 1'b0, clr = 1'b0;
    logic brk_flag, brk_irq;
    int   checks = 0, errors = 0, irq_cnt = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    lin_break_detect u_lin_break_detect (
        .clk(clk), .rst(rst), .en(en), .rx_in(rx_in), .bit_tick(bit_tick),
        .len_sel(len_sel), .clr(clr), .brk_flag(brk_flag), .brk_irq(brk_irq)
    );

    always @(negedge clk) if (brk_irq) irq_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic v, input logic c = 1'b0);
        @(negedge clk) rx_in = v;
        @(negedge clk);
        @(negedge clk) begin bit_tick = 1'b1; clr = c; end
        @(negedge clk) begin bit_tick = 1'b0; clr = 1'b0; end
    endtask

    task automatic put_run(input int n);
        for (int i = 0; i < n; i++) put_bit(1'b0);
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flag after reset", brk_flag, 0);
        check("R1 irq after reset", brk_irq, 0);
    endtask

    task automatic t_short();
        int base;
        len_sel = 1'b0; base = irq_cnt;
        put_bit(1'b1);
        put_run(9);
        check("R2 nine lows no flag", brk_flag, 0);
        put_bit(1'b0);
        check("R2 ten lows set flag", brk_flag, 1);
        check("R6 irq pulse present", brk_irq, 1);
        @(negedge clk);
        check("R6 irq one cycle", brk_irq, 0);
        check("R6 one pulse", irq_cnt - base, 1);
        put_bit(1'b1);
        check("R5 flag sticky", brk_flag, 1);
        pulse_clr();
        check("R5 clr clears", brk_flag, 0);
    endtask

    task automatic t_long();
        len_sel = 1'b1;
        put_bit(1'b1);
        put_run(10);
        put_bit(1'b1);
        check("R3 ten lows not enough", brk_flag, 0);
        put_run(11);
        check("R3 eleven lows set flag", brk_flag, 1);
        put_bit(1'b1);
        pulse_clr();
        len_sel = 1'b0;
    endtask

    task automatic t_abort();
        put_run(9);
        put_bit(1'b1);
        check("R4 abort on early high", brk_flag, 0);
        put_run(10);
        check("R4 new edge succeeds", brk_flag, 1);
        put_bit(1'b1);
        pulse_clr();
    endtask

    task automatic t_long_low();
        int base;
        base = irq_cnt;
        put_run(10);
        pulse_clr();
        put_run(15);
        check("R7 no redetect in low run", brk_flag, 0);
        check("R7 single irq for long low", irq_cnt - base, 1);
        put_bit(1'b1);
        put_run(10);
        check("R7 rearm after delimiter", brk_flag, 1);
        put_bit(1'b1);
        pulse_clr();
    endtask

    task automatic t_same_cycle();
        put_run(9);
        put_bit(1'b0, 1'b1);
        check("R5 detect beats clr", brk_flag, 1);
        put_bit(1'b1);
        pulse_clr();
    endtask

    task automatic t_enable();
        int base;
        base = irq_cnt;
        put_run(5);
        @(negedge clk) en = 1'b0;
        @(negedge clk) en = 1'b1;
        put_run(8);
        check("R8 partial count discarded", brk_flag, 0);
        @(negedge clk) en = 1'b0;
        put_bit(1'b1);
        put_run(12);
        check("R8 disabled no detect", brk_flag, 0);
        @(negedge clk) en = 1'b1;
        put_run(12);
        check("R8 low at enable no count", brk_flag, 0);
        check("R8 no irq", irq_cnt - base, 0);
        put_bit(1'b1);
        put_run(10);
        check("R8 works after re-enable", brk_flag, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        en = 1'b1;
        t_short();
        t_long();
        t_abort();
        t_long_low();
        t_same_cycle();
        t_enable();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule